// File: doc/BRIEF.md
# Output Transition Time Stamper

This block watches a handful of synchronously generated output signals (for example a shutter and a trigger line) on the same clock that produces them. A free-running cycle counter supplies the time base. Whenever one or more of the watched signals changes level, the block forms one record that holds the counter value, a bitmask of the signals that changed and the new level of every watched signal. Records queue in a small first-in first-out store and leave through a valid/ready stream, which a scatter-gather DMA engine drains into memory.

The counter rolls over silently. In the cycle where it holds its all-ones value, the block emits a record with a wrap flag set, so that software can extend the time base. Any level changes seen in that same cycle go into that record. When the store is full, new records are dropped and a sticky overflow flag is raised. The flag stays set until reset.

Top module: `xition_stamper`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rec_valid` and `rec_lost` are 0. The time counter reads 0 in the first clocked cycle after reset.
- R2: The record word is packed, from MSB to LSB, as: wrap flag (1 bit), time (TW bits), change mask (NSIG bits), new levels (NSIG bits). Bit i of the mask and of the levels refers to `watch_in[i]`.
- R3: The time counter advances by one each clock cycle. A level change on `watch_in`, first sampled at a clock edge, produces one record whose time field equals the counter value at that edge.
- R4: Changes on several signals at the same edge share one record. Its mask has a 1 for each changed signal, and its level field holds the sampled value of all signals.
- R5: The previous level of each signal is taken as 0 out of reset, so a signal that is high at the first edge after reset is recorded as a rising change at time 0.
- R6: At the edge where the counter holds all ones, a record is produced with the wrap flag set to 1 and time all ones, even with no level change. Any changes at that edge are merged into it. The counter then reads 0. Records other than wrap records carry a wrap flag of 0.
- R7: Records leave in the order they were formed. `rec_valid` is 1 exactly while records are held. While `rec_valid` is 1 and `rec_ready` is 0, `rec_data` holds steady. A record leaves at an edge where both are 1.
- R8: The store holds DEPTH records. A record formed while DEPTH records are held is dropped, even if one leaves at the same edge. Such a drop sets `rec_lost` from the next cycle on, and it stays 1 until reset.
- R9: An edge with no level change and no counter wrap produces no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the signal generators |
| rst_n | input | 1 | Asynchronous reset, active low |
| watch_in | input | NSIG | Watched output signals, synchronous to clk |
| rec_valid | output | 1 | A record is offered |
| rec_ready | input | 1 | The consumer takes the offered record |
| rec_data | output | 1+TW+2*NSIG | Offered record (wrap, time, mask, levels) |
| rec_lost | output | 1 | Sticky: at least one record was dropped |

## Verification
The bench builds the block with an 8-bit counter, three watched signals and a four-entry store. With these values the counter wraps every 256 cycles, so many wrap records occur during the run, some of them merged with level changes. The store is also small enough that a short stall of `rec_ready` during bursts of changes drops records and sets the overflow flag. A reference queue in the bench, driven from the requirements, follows every edge under random changes and random back-pressure.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  typedef enum logic {
    REC_EDGE = 1'b0,
    REC_WRAP = 1'b1
  } rec_kind_t;
endpackage

// File: rtl/stamp_counter.sv
module stamp_counter #(
  parameter int TW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [TW-1:0] time_now,
  output logic          wrap_now
);
  localparam logic [TW-1:0] TOP_VAL = '1;

  function automatic logic [TW-1:0] tick(input logic [TW-1:0] v);
    return v + TW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_now <= '0;
    else        time_now <= tick(time_now);
  end

  assign wrap_now = (time_now == TOP_VAL);
endmodule

// File: rtl/edge_sense.sv
module edge_sense #(
  parameter int NSIG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSIG-1:0] lvl_in,
  output logic [NSIG-1:0] chg_mask
);
  logic [NSIG-1:0] last_lvl;

  for (genvar i = 0; i < NSIG; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_lvl[i] <= 1'b0;
      else        last_lvl[i] <= lvl_in[i];
    end
    assign chg_mask[i] = lvl_in[i] ^ last_lvl[i];
  end
endmodule

// File: rtl/rec_fifo.sv
module rec_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_word,
  output logic         full,
  output logic         rd_valid,
  input  logic         rd_take,
  output logic [W-1:0] rd_word
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;
  logic          do_wr, do_rd;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + AW'(1);
  endfunction

  assign full     = (fill == FULL_CNT);
  assign rd_valid = (fill != '0);
  assign do_wr    = wr_en && !full;
  assign do_rd    = rd_valid && rd_take;
  assign rd_word  = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) store[wr_ptr] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_wr) wr_ptr <= step(wr_ptr);
      if (do_rd) rd_ptr <= step(rd_ptr);
      case ({do_wr, do_rd})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/xition_stamper.sv
module xition_stamper #(
  parameter int NSIG  = 4,
  parameter int TW    = 40,
  parameter int DEPTH = 16,
  localparam int RW   = 1 + TW + 2 * NSIG
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSIG-1:0] watch_in,
  output logic            rec_valid,
  input  logic            rec_ready,
  output logic [RW-1:0]   rec_data,
  output logic            rec_lost
);
  import stamp_pkg::*;

  logic [TW-1:0]   time_now;
  logic            wrap_now;
  logic [NSIG-1:0] chg_mask;
  logic            rec_req;
  logic            fifo_full;
  logic            drop_now;
  rec_kind_t       kind;
  logic [RW-1:0]   rec_word;

  function automatic logic [RW-1:0] pack_rec(input rec_kind_t k,
                                             input logic [TW-1:0] t,
                                             input logic [NSIG-1:0] m,
                                             input logic [NSIG-1:0] l);
    return {k, t, m, l};
  endfunction

  stamp_counter #(.TW(TW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .time_now(time_now), .wrap_now(wrap_now)
  );

  edge_sense #(.NSIG(NSIG)) u_sense (
    .clk(clk), .rst_n(rst_n), .lvl_in(watch_in), .chg_mask(chg_mask)
  );

  assign kind     = wrap_now ? REC_WRAP : REC_EDGE;
  assign rec_req  = (|chg_mask) || wrap_now;
  assign rec_word = pack_rec(kind, time_now, chg_mask, watch_in);
  assign drop_now = rec_req && fifo_full;

  rec_fifo #(.W(RW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_en(rec_req), .wr_word(rec_word), .full(fifo_full),
    .rd_valid(rec_valid), .rd_take(rec_ready), .rd_word(rec_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rec_lost <= 1'b0;
    else if (drop_now) rec_lost <= 1'b1;
  end
endmodule

// File: rtl/xition_stamper_chk.sv
module xition_stamper_chk #(
  parameter int NSIG = 4,
  parameter int TW   = 40,
  parameter int RW   = 1 + TW + 2 * NSIG
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rec_valid,
  input logic          rec_ready,
  input logic [RW-1:0] rec_data,
  input logic          rec_lost,
  input logic [TW-1:0] time_now,
  input logic          wrap_now,
  input logic          rec_req,
  input logic          fifo_full
);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_data));

  // R8
  lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_lost |=> rec_lost);

  // R8
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_req && fifo_full |=> rec_lost);

  // R3
  time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_now |=> time_now == TW'($past(time_now) + TW'(1)));

  // R6
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_now |=> time_now == '0);

  // R9
  no_req_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_req && !rec_valid |=> !rec_valid);
endmodule

bind xition_stamper xition_stamper_chk #(.NSIG(NSIG), .TW(TW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
  .rec_data(rec_data), .rec_lost(rec_lost), .time_now(time_now),
  .wrap_now(wrap_now), .rec_req(rec_req), .fifo_full(fifo_full)
);

// File: tb/xition_stamper_bench.sv
module xition_stamper_bench;
  localparam int NSIG  = 3;
  localparam int TW    = 8;
  localparam int DEPTH = 4;
  localparam int RW    = 1 + TW + 2 * NSIG;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSIG-1:0] watch_in = '0;
  logic            rec_valid;
  logic            rec_ready = 1'b0;
  logic [RW-1:0]   rec_data;
  logic            rec_lost;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xition_stamper #(.NSIG(NSIG), .TW(TW), .DEPTH(DEPTH)) u_xition_stamper (
    .clk(clk), .rst_n(rst_n), .watch_in(watch_in), .rec_valid(rec_valid),
    .rec_ready(rec_ready), .rec_data(rec_data), .rec_lost(rec_lost)
  );

  function automatic logic [RW-1:0] mk_rec(input logic w, input logic [TW-1:0] t,
                                           input logic [NSIG-1:0] m,
                                           input logic [NSIG-1:0] l);
    mk_rec = '0;
    mk_rec[RW-1] = w;
    mk_rec[RW-2 -: TW] = t;
    mk_rec[2*NSIG-1 -: NSIG] = m;
    mk_rec[NSIG-1:0] = l;
  endfunction

  // reference model built from the requirements
  logic [RW-1:0]   ref_q[$];
  logic [TW-1:0]   ref_time;
  logic [NSIG-1:0] ref_prev;
  logic            ref_lost;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q.delete();
      ref_time = '0;
      ref_prev = '0;
      ref_lost = 1'b0;
    end else begin
      logic [NSIG-1:0] m;
      logic w, pop, req;
      int held;
      m    = watch_in ^ ref_prev;
      w    = (ref_time == {TW{1'b1}});
      req  = (m != '0) || w;
      held = ref_q.size();
      pop  = (held > 0) && rec_ready;
      if (pop) void'(ref_q.pop_front());
      if (req) begin
        if (held >= DEPTH) ref_lost = 1'b1;
        else ref_q.push_back(mk_rec(w, ref_time, m, watch_in));
      end
      ref_prev = watch_in;
      ref_time = ref_time + TW'(1);
    end
  end

  task automatic check(input bit ok, input string tag, input logic [RW-1:0] act,
                       input logic [RW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_cycle();
    bit ev;
    ev = (ref_q.size() > 0);
    check(rec_valid == ev, ev ? "R7 valid" : "R9 valid", RW'(rec_valid), RW'(ev));
    if (ev && rec_valid) begin
      logic [RW-1:0] e;
      e = ref_q[0];
      if (e[RW-1])
        check(rec_data == e, "R6 wrap record", rec_data, e);
      else if ($countones(e[2*NSIG-1 -: NSIG]) > 1)
        check(rec_data == e, "R4 shared record", rec_data, e);
      else
        check(rec_data == e, "R3 R2 record", rec_data, e);
    end
    check(rec_lost == ref_lost, "R8 lost flag", RW'(rec_lost), RW'(ref_lost));
  endtask

  task automatic step(input logic [NSIG-1:0] s, input logic r);
    @(negedge clk);
    compare_cycle();
    watch_in  = s;
    rec_ready = r;
  endtask

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rec_valid == 1'b0, "R1 valid in reset", RW'(rec_valid), RW'(0));
    check(rec_lost == 1'b0, "R1 lost in reset", RW'(rec_lost), RW'(0));
    watch_in  = 3'b101;
    rec_ready = 1'b0;
    rst_n     = 1'b1;
    @(negedge clk);
    // R5 high level after reset counts as a change at time 0
    check(rec_data == mk_rec(1'b0, '0, 3'b101, 3'b101), "R5 first record",
          rec_data, mk_rec(1'b0, '0, 3'b101, 3'b101));
    check(rec_valid == 1'b1, "R5 first valid", RW'(rec_valid), RW'(1));
    compare_cycle();
    // stalled: data held (R7), no new records while steady (R9)
    repeat (4) step(3'b101, 1'b0);
    step(3'b010, 1'b1);             // all three change together (R4)
    step(3'b010, 1'b1);
    repeat (6) step(3'b010, 1'b1);
    // random traffic across several counter wraps (R3 R6)
    for (int i = 0; i < 1500; i++) begin
      logic [NSIG-1:0] s;
      s = watch_in;
      if (($urandom % 6) == 0) s = s ^ NSIG'($urandom);
      step(s, ($urandom % 4) != 0);
    end
    // overflow burst (R8)
    for (int i = 0; i < 12; i++) step(~watch_in, 1'b0);
    check(rec_lost == 1'b1, "R8 lost after burst", RW'(rec_lost), RW'(1));
    repeat (20) step(watch_in, 1'b1);
    for (int i = 0; i < 400; i++) begin
      logic [NSIG-1:0] s;
      s = watch_in;
      if (($urandom % 5) == 0) s = s ^ NSIG'($urandom);
      step(s, ($urandom % 3) != 0);
    end
    check(rec_lost == 1'b1, "R8 lost stays set", RW'(rec_lost), RW'(1));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule